// File: doc/BRIEF.md
# Burst Flash Configuration Register Unit

This block keeps the 16-bit burst configuration word of a behavioural two-bank flash interface. The host reaches the word only through command sequences written on the 32-bit bus; it has no place in the memory map. A set sequence loads a new word. The load is dropped when the embedded program/erase algorithm reports busy on the last cycle. A read-configuration sequence records which bank it was aimed at. From then on, reads to that bank return the word, and reads to the other bank return array data.

A write cycle is any rising clock edge that sees chip enable and write enable both low. The read data path is combinational from the address, the enables and the held state. The array is a stub: its word is the address with all upper bits set. The register value is also driven out as `cfg_q` for the burst logic. The bus is a plain strobe bus. There is no valid/ready handshake and no back-pressure, because every write cycle is taken in the cycle it appears.

Top module: `burst_cfg_unit`

## Requirements
- R1: After hardware reset `cfg_q` is 16'h0440 (bit 6 set, bits 13..10 hold latency code 1, the rest zero), and every read returns array data.
- R2: A read occurs when `ce_n` and `oe_n` are both low. Outside configuration mode it returns the array stub word: the address zero-extended, with bits 31..ADDR_W all ones. When `ce_n` or `oe_n` is high, `rdata` is zero.
- R3: The set sequence is four write cycles: address low 11 bits 0x555 with data low byte 0xAA, then 0x2AA with 0x55, then 0x555 with 0xD0, then any address. `cfg_q` takes `wdata[15:0]` of the fourth cycle from the next cycle on.
- R4: If `algo_busy` is high on the fourth cycle of the set sequence, `cfg_q` keeps its previous value.
- R5: The read-configuration sequence is three write cycles: 0x555/0xAA, then 0x2AA/0x55, then 0x555/0xC6. Address bit ADDR_W-1 of the third cycle selects the bank. Later reads whose top address bit matches that bank return `{16'h0, cfg_q}`, and reads to the other bank return array data.
- R6: The read-configuration command is accepted with either bank's address, since the unlock and command compares use only address bits 10..0.
- R7: A write cycle that does not match the expected unlock or command pair returns the decoder to idle. A later fourth-style write then changes nothing.
- R8: In idle, a write whose data low byte is 0xF0 returns both banks to array reads.
- R9: Write strobes while `ce_n` is high are ignored. Deasserting chip enable changes neither `cfg_q` nor the configuration-read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; write cycles are sampled on its rising edge |
| rst_n | input | 1 | Active-low hardware reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address; top bit is the bank |
| wdata | input | DATA_W | Write data bus |
| algo_busy | input | 1 | Embedded program/erase algorithm active |
| rdata | output | DATA_W | Read data bus |
| cfg_q | output | 16 | Current configuration word |

## Verification
The set sequence is driven with the algorithm idle and then busy. This separates a load that is gated on the final cycle from one that is not. The read-configuration sequence is issued on bank 1 and on bank 0, and both banks are read after each. This shows that the bank is latched with the command and not taken from the read address. Sequences broken at the second and at the third cycle, writes with chip enable high, the 0xF0 reset command and a hardware reset in the middle of configuration mode show that only complete, enabled sequences change state, and that only the two reset paths clear it.

// File: rtl/bcfg_pkg.sv
`timescale 1ns/1ps
package bcfg_pkg;
  localparam int CFG_W = 16;
  localparam int CMP_W = 11;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h0440;
  localparam logic [CMP_W-1:0] UNLK_A1 = 11'h555;
  localparam logic [CMP_W-1:0] UNLK_A2 = 11'h2AA;
  localparam logic [7:0] UNLK_D1   = 8'hAA;
  localparam logic [7:0] UNLK_D2   = 8'h55;
  localparam logic [7:0] CMD_SET   = 8'hD0;
  localparam logic [7:0] CMD_RDCFG = 8'hC6;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  typedef enum logic [1:0] {S_IDLE, S_UNLK1, S_UNLK2, S_SETW} seq_e;
endpackage

// File: rtl/bcfg_seq.sv
`timescale 1ns/1ps
module bcfg_seq
  import bcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CMP_W-1:0] a_lo,
  input  logic             bank_bit,
  input  logic [7:0]       wbyte,
  output logic             set_stb,
  output logic             rd_mode,
  output logic             rd_bank
);
  seq_e st, nxt;
  logic enter_rd, rst_cmd;

  always_comb begin
    nxt      = st;
    set_stb  = 1'b0;
    enter_rd = 1'b0;
    rst_cmd  = 1'b0;
    if (wr_stb) begin
      case (st)
        S_IDLE: begin
          if (a_lo == UNLK_A1 && wbyte == UNLK_D1) nxt = S_UNLK1;
          else if (wbyte == CMD_RESET)              rst_cmd = 1'b1;
        end
        S_UNLK1: nxt = (a_lo == UNLK_A2 && wbyte == UNLK_D2) ? S_UNLK2 : S_IDLE;
        S_UNLK2: begin
          nxt = S_IDLE;
          if (a_lo == UNLK_A1 && wbyte == CMD_SET)        nxt = S_SETW;
          else if (a_lo == UNLK_A1 && wbyte == CMD_RDCFG) enter_rd = 1'b1;
        end
        S_SETW: begin
          nxt     = S_IDLE;
          set_stb = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_mode <= 1'b0;
      rd_bank <= 1'b0;
    end else begin
      st <= nxt;
      if (enter_rd) begin
        rd_mode <= 1'b1;
        rd_bank <= bank_bit;
      end else if (rst_cmd) begin
        rd_mode <= 1'b0;
      end
    end
  end

  // R8: reset command leaves configuration mode
  assert_reset_cmd_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !rd_mode);
  // R7: wrong second cycle aborts the sequence
  assert_abort_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNLK1 && wr_stb && a_lo != UNLK_A2) |=> (st == S_IDLE));
endmodule

// File: rtl/bcfg_store.sv
`timescale 1ns/1ps
module bcfg_store
  import bcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             busy,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= CFG_DEFAULT;
    else if (set_stb && !busy) q <= din;
  end

  // R4: busy on the final cycle drops the update
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && busy) |=> $stable(q));
endmodule

// File: rtl/bcfg_rdpath.sv
`timescale 1ns/1ps
module bcfg_rdpath
  import bcfg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_mode,
  input  logic              rd_bank,
  input  logic [CFG_W-1:0]  cfg,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - ADDR_W;
  logic              hit;
  logic [DATA_W-1:0] array_word;

  assign hit        = rd_mode && (addr[ADDR_W-1] == rd_bank);
  assign array_word = {{PAD_W{1'b1}}, addr};

  always_comb begin
    if (!rd_en)   rdata = '0;
    else if (hit) rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
    else          rdata = array_word;
  end
endmodule

// File: rtl/burst_cfg_unit.sv
`timescale 1ns/1ps
module burst_cfg_unit
  import bcfg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              algo_busy,
  output logic [DATA_W-1:0] rdata,
  output logic [CFG_W-1:0]  cfg_q
);
  logic wr_stb, set_stb, rd_mode, rd_bank;
  logic unused_hi;

  assign wr_stb    = !ce_n && !we_n;
  assign unused_hi = ^wdata[DATA_W-1:CFG_W];

  bcfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .a_lo(addr[CMP_W-1:0]), .bank_bit(addr[ADDR_W-1]), .wbyte(wdata[7:0]),
    .set_stb(set_stb), .rd_mode(rd_mode), .rd_bank(rd_bank)
  );

  bcfg_store u_store (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .busy(algo_busy),
    .din(wdata[CFG_W-1:0]), .q(cfg_q)
  );

  bcfg_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_en(!ce_n && !oe_n), .addr(addr), .rd_mode(rd_mode),
    .rd_bank(rd_bank), .cfg(cfg_q), .rdata(rdata)
  );

  // R9: chip enable high never moves the register
  assert_ce_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(cfg_q));
  // R3: completed set sequence loads the fourth-cycle data
  assert_set_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !algo_busy) |=> (cfg_q == $past(wdata[CFG_W-1:0])));
  // R5: a configuration read carries zeros in the upper half
  assert_cfg_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && !ce_n && !oe_n && addr[ADDR_W-1] == rd_bank) |-> (rdata[DATA_W-1:CFG_W] == '0));
endmodule

// File: tb/burst_cfg_unit_test.sv
`timescale 1ns/1ps
module burst_cfg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, algo_busy = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] cfg_q;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_cfg_unit uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .algo_busy(algo_busy), .rdata(rdata), .cfg_q(cfg_q)
  );

  typedef struct packed {
    logic        ce, we, oe, busy;
    logic [19:0] a;
    logic [31:0] d;
    logic [31:0] exp_rd;
    logic [15:0] exp_cfg;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TAB [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,20'h00123,32'h0,32'hFFF00123,16'h0440},     // R2 array read
    '{1'b0,1'b0,1'b1,1'b0,20'h00555,32'hAA,32'h0,16'h0440},
    '{1'b0,1'b0,1'b1,1'b0,20'h002AA,32'h55,32'h0,16'h0440},
    '{1'b0,1'b0,1'b1,1'b0,20'h00555,32'hD0,32'h0,16'h0440},
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,32'hABCD1C2B,32'h0,16'h1C2B},     // R3 load
    '{1'b0,1'b1,1'b0,1'b0,20'h00010,32'h0,32'hFFF00010,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b0,20'h00555,32'hAA,32'h0,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b0,20'h002AA,32'h55,32'h0,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b0,20'h00555,32'hD0,32'h0,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b1,20'h00000,32'h3333,32'h0,16'h1C2B},         // R4 busy drop
    '{1'b0,1'b0,1'b1,1'b0,20'h80555,32'hAA,32'h0,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b0,20'h802AA,32'h55,32'h0,16'h1C2B},
    '{1'b0,1'b0,1'b1,1'b0,20'h80555,32'hC6,32'h0,16'h1C2B},
    '{1'b0,1'b1,1'b0,1'b0,20'h80004,32'h0,32'h00001C2B,16'h1C2B},     // R5 bank hit
    '{1'b0,1'b1,1'b0,1'b0,20'h00004,32'h0,32'hFFF00004,16'h1C2B},     // R5 other bank
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,32'hF0,32'h0,16'h1C2B},           // R8 reset cmd
    '{1'b0,1'b1,1'b0,1'b0,20'h80004,32'h0,32'hFFF80004,16'h1C2B}      // R8 array again
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic o, input logic b,
                     input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; algo_busy = b; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [19:0] a);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 default cfg in reset", {16'h0, cfg_q}, 32'h0440);
    @(negedge clk); rst_n = 1'b1;
    rd(20'h80004);
    chk("R1 array read after reset", rdata, 32'hFFF80004);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 20'h00123, 32'h0);
    chk("R2 oe_n high gives zero", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(TAB[i].ce, TAB[i].we, TAB[i].oe, TAB[i].busy, TAB[i].a, TAB[i].d);
      chk($sformatf("table row %0d rdata (R2 R3 R4 R5 R8)", i), rdata, TAB[i].exp_rd);
      chk($sformatf("table row %0d cfg (R3 R4)", i), {16'h0, cfg_q}, {16'h0, TAB[i].exp_cfg});
    end

    // R9: full set sequence with chip enable high is ignored
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h00555, 32'hAA);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h002AA, 32'h55);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h00555, 32'hD0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 20'h00000, 32'h00AA);
    chk("R9 ce_n high writes ignored", {16'h0, cfg_q}, 32'h1C2B);

    // R6: read-config command on bank 0
    wr(20'h00555, 32'hAA); wr(20'h002AA, 32'h55); wr(20'h00555, 32'hC6);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 20'h00008, 32'h0);
    chk("R2 ce_n high gives zero", rdata, 32'h0);
    rd(20'h00008);
    chk("R6 bank0 config read (R9 mode kept over ce_n high)", rdata, 32'h00001C2B);
    rd(20'h80008);
    chk("R6 bank1 array read", rdata, 32'hFFF80008);
    wr(20'h0, 32'hF0);

    // R7: abort at second cycle, then stray command and data
    wr(20'h00555, 32'hAA); wr(20'h002AA, 32'h56); wr(20'h00555, 32'hD0); wr(20'h0, 32'h7777);
    chk("R7 abort at second cycle", {16'h0, cfg_q}, 32'h1C2B);
    // R7: abort at third cycle
    wr(20'h00555, 32'hAA); wr(20'h002AA, 32'h55); wr(20'h00555, 32'h12); wr(20'h0, 32'h4444);
    chk("R7 abort at third cycle", {16'h0, cfg_q}, 32'h1C2B);
    rd(20'h00020);
    chk("R7 no mode entered", rdata, 32'hFFF00020);

    // R1: hardware reset in config mode restores default and array reads
    wr(20'h80555, 32'hAA); wr(20'h802AA, 32'h55); wr(20'h80555, 32'hC6);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(20'h80004);
    chk("R1 reset clears config mode", rdata, 32'hFFF80004);
    chk("R1 reset restores default", {16'h0, cfg_q}, 32'h0440);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule